// File: doc/BRIEF.md
# Real-time clock with alarm and stopwatch

This block keeps the time of day. It counts seconds, minutes and hours in one packed word, and it keeps a separate day count. A one-second pulse from a slower clock domain advances it. The pulse must already be synchronized and must be one cycle wide. Software sets and reads the clock through a small register port with one-cycle writes. Reads are combinational and use the same address lines.

On each accepted second the block finds every unit that rolls over and raises one event flag for each. It also steps a stopwatch that counts down in minutes, and it compares the updated time and day with an alarm setting. An enable mask filters the events. Events that pass the mask collect in a sticky status register, and any set status bit drives the interrupt request. Software clears status bits by writing ones to them.

Register addresses: 0 control, 1 time, 2 day, 3 alarm time, 4 alarm day, 5 stopwatch, 6 interrupt enable, 7 interrupt status.

Top module: `rtc_core`

## Requirements
- R1: Control register (address 0) bit 7 enables counting and is the only bit that reads back. While it is 0, the second pulse has no effect on time, day, stopwatch or status.
- R2: The time word (address 1) holds hours in bits 31:24, minutes in bits 21:16 and seconds in bits 5:0. All other bits read as 0. The alarm time word (address 3) uses the same layout.
- R3: Each accepted pulse advances seconds by one and raises event bit 4. When seconds reach 60 they return to 0, minutes advance and event bit 1 is raised.
- R4: When minutes reach 60 they return to 0, hours advance and event bit 5 is raised. When hours reach 24 they return to 0, the day count advances and event bit 3 is raised.
- R5: The day count (address 2) is 9 bits wide. It goes from 511 to 0.
- R6: The stopwatch (address 5, 6 bits, reset value 0x3F) changes only on a minute rollover. It stays put when it holds 0x3F, becomes 0x3F when it holds 0, and otherwise counts down by one.
- R7: Event bit 0 is raised on any minute rollover after which the stopwatch holds 0x3F.
- R8: Event bit 6 is raised when the updated time fields and day count after a pulse equal the alarm time and the alarm day (address 4).
- R9: Events are ANDed with the interrupt enable register (address 6, bits 6:0) and ORed into the sticky status register (address 7). A masked event leaves status unchanged.
- R10: The interrupt request is high exactly while some status bit is set.
- R11: Writing a 1 to a status bit clears it. If an enabled event for that bit occurs in the same cycle, the bit stays set.
- R12: A software write to time or day takes effect on the next cycle and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_pulse | input | 1 | One-cycle pulse marking one elapsed second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The pulse is applied to several starting times. A mid-minute start checks that only the seconds event fires. Starts at 59 seconds, 59:59 and 23:59:59 with day 511 check that each stage of the carry chain fires its own flag and nothing beyond it, and that the day wraps. The stopwatch is loaded with small values and stepped across successive minute rollovers, which separates a plain decrement from the zero-to-idle step and from the idle-hold case. The pulse is also applied with counting disabled, with every event masked, and next to status clears, so that gating, masking and the clear-versus-set priority each show up as a visibly different result.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg
// Shared event bit positions, field widths and register addresses for the
// real-time clock. The event positions are visible to software and are fixed.
package rtc_pkg;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 8;
    localparam int DAY_W   = 9;
    localparam int SW_W    = 6;
    localparam int NUM_EV  = 7;

    localparam int EV_STOPW = 0;
    localparam int EV_MIN   = 1;
    localparam int EV_DAY   = 3;
    localparam int EV_SEC   = 4;
    localparam int EV_HOUR  = 5;
    localparam int EV_ALARM = 6;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_TIME   = 3'd1,
        A_DAY    = 3'd2,
        A_ALTIME = 3'd3,
        A_ALDAY  = 3'd4,
        A_STOPW  = 3'd5,
        A_IEN    = 3'd6,
        A_STAT   = 3'd7
    } rtc_addr_e;
endpackage

// File: rtl/rtc_time_chain.sv
// Module rtc_time_chain
// Holds seconds, minutes, hours and the day count, and works out their next
// values together with the rollover events for one second step.
// Assumes: tick is a single-cycle qualified second. A software write to a field
// overrides the step for that field and raises no events.
module rtc_time_chain #(
    parameter int SEC_W  = 6,
    parameter int MIN_W  = 6,
    parameter int HOUR_W = 8,
    parameter int DAY_W  = 9,
    parameter int SEC_MAX  = 60,
    parameter int MIN_MAX  = 60,
    parameter int HOUR_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_time,
    input  logic              wr_day,
    input  logic [SEC_W-1:0]  w_sec,
    input  logic [MIN_W-1:0]  w_min,
    input  logic [HOUR_W-1:0] w_hour,
    input  logic [DAY_W-1:0]  w_day,
    output logic [SEC_W-1:0]  sec,
    output logic [MIN_W-1:0]  mins,
    output logic [HOUR_W-1:0] hour,
    output logic [DAY_W-1:0]  day,
    output logic [SEC_W-1:0]  nx_sec,
    output logic [MIN_W-1:0]  nx_min,
    output logic [HOUR_W-1:0] nx_hour,
    output logic [DAY_W-1:0]  nx_day,
    output logic              ev_sec,
    output logic              ev_min,
    output logic              ev_hour,
    output logic              ev_day
);
    logic [SEC_W:0]  sec_inc;
    logic [MIN_W:0]  min_inc;
    logic [HOUR_W:0] hour_inc;
    logic            sec_wrap, min_wrap, hour_wrap;

    // Next values for one second step: carries ripple from seconds upward
    always_comb begin
        sec_inc   = {1'b0, sec} + 1'b1;
        min_inc   = {1'b0, mins} + 1'b1;
        hour_inc  = {1'b0, hour} + 1'b1;
        sec_wrap  = (sec_inc >= (SEC_W+1)'(SEC_MAX));
        min_wrap  = sec_wrap && (min_inc >= (MIN_W+1)'(MIN_MAX));
        hour_wrap = min_wrap && (hour_inc >= (HOUR_W+1)'(HOUR_MAX));
        nx_sec    = sec_wrap ? '0 : sec_inc[SEC_W-1:0];
        nx_min    = min_wrap ? '0 : (sec_wrap ? min_inc[MIN_W-1:0] : mins);
        nx_hour   = hour_wrap ? '0 : (min_wrap ? hour_inc[HOUR_W-1:0] : hour);
        nx_day    = hour_wrap ? day + 1'b1 : day;
    end

    // Rollover events are raised only for an accepted step
    always_comb begin
        ev_sec  = tick;
        ev_min  = tick && sec_wrap;
        ev_hour = tick && min_wrap;
        ev_day  = tick && hour_wrap;
    end

    // Time field registers: a software write beats the step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec  <= '0;
            mins <= '0;
            hour <= '0;
        end else if (wr_time) begin
            sec  <= w_sec;
            mins <= w_min;
            hour <= w_hour;
        end else if (tick) begin
            sec  <= nx_sec;
            mins <= nx_min;
            hour <= nx_hour;
        end
    end

    // Day register: a software write beats the step
    always_ff @(posedge clk) begin
        if (!rst_n)      day <= '0;
        else if (wr_day) day <= w_day;
        else if (tick)   day <= nx_day;
    end

    // R12
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_time) |=> ($stable(sec) && $stable(mins) && $stable(hour)));
    // R4
    hour_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_day && !wr_time) |=> (hour == '0 && mins == '0 && sec == '0));
    // R5
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_day && !wr_day && day == {DAY_W{1'b1}}) |=> (day == '0));
endmodule

// File: rtl/rtc_stopwatch.sv
// Module rtc_stopwatch
// Minute-granular countdown. The all-ones value means idle: it holds there,
// and a count that reaches zero moves to idle on the next minute.
// Assumes: step is high for one cycle on each minute rollover.
module rtc_stopwatch #(
    parameter int SW_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            wr,
    input  logic [SW_W-1:0] w_val,
    output logic [SW_W-1:0] value,
    output logic            ev_idle
);
    localparam logic [SW_W-1:0] IDLE = {SW_W{1'b1}};
    logic [SW_W-1:0] nx_val;

    // Value after one minute step
    always_comb begin
        if (value == IDLE)     nx_val = IDLE;
        else if (value == '0)  nx_val = IDLE;
        else                   nx_val = value - 1'b1;
        ev_idle = step && (nx_val == IDLE);
    end

    // Stopwatch register: a software write beats the step
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= IDLE;
        else if (wr)   value <= w_val;
        else if (step) value <= nx_val;
    end

    // R6
    sw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr && value == '0) |=> (value == IDLE));
    // R6
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr) |=> $stable(value));
endmodule

// File: rtl/rtc_event_reg.sv
// Module rtc_event_reg
// Interrupt enable mask and sticky status. Status bits are set by enabled
// events and cleared by writing ones; a set and a clear in the same cycle
// leave the bit set.
// Assumes: ev_in bits are single-cycle strobes.
module rtc_event_reg #(
    parameter int NUM_EV = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic              wr_ien,
    input  logic              wr_clr,
    input  logic [NUM_EV-1:0] w_bits,
    output logic [NUM_EV-1:0] ien,
    output logic [NUM_EV-1:0] status,
    output logic              irq
);
    logic [NUM_EV-1:0] clr_mask;
    logic [NUM_EV-1:0] set_mask;

    // Clear and set masks for this cycle
    always_comb begin
        clr_mask = wr_clr ? w_bits : '0;
        set_mask = ev_in & ien;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (wr_ien) ien <= w_bits;
    end

    // Sticky status: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_mask;
    end

    // Request follows any pending status bit
    always_comb irq = |status;

    // R9
    ev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_in & ien)) |=> ((status & $past(ev_in & ien)) == $past(ev_in & ien)));
    // R9
    ev_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(ev_in & ien)) == '0));
endmodule

// File: rtl/rtc_core.sv
// Module rtc_core
// Top of the real-time clock: control enable, register port, alarm compare and
// event assembly around the time chain, stopwatch and event register.
// Assumes: sec_pulse is synchronous to clk and one cycle wide; reads are
// combinational on bus_addr.
module rtc_core
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_pulse,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic              run_en;
    logic              tick;
    logic [SEC_W-1:0]  al_sec;
    logic [MIN_W-1:0]  al_min;
    logic [HOUR_W-1:0] al_hour;
    logic [DAY_W-1:0]  al_day;

    logic [SEC_W-1:0]  sec, nx_sec;
    logic [MIN_W-1:0]  mins, nx_min;
    logic [HOUR_W-1:0] hour, nx_hour;
    logic [DAY_W-1:0]  day, nx_day;
    logic              ev_sec, ev_min, ev_hour, ev_day;
    logic [SW_W-1:0]   sw_val;
    logic              ev_idle;
    logic              alarm_hit;
    logic [NUM_EV-1:0] ev_vec;
    logic [NUM_EV-1:0] ien, status;

    logic wr_ctrl, wr_time, wr_day, wr_altime, wr_alday, wr_sw, wr_ien, wr_stat;

    // Address decode of the write strobe
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
        wr_time   = bus_wr && (bus_addr == A_TIME);
        wr_day    = bus_wr && (bus_addr == A_DAY);
        wr_altime = bus_wr && (bus_addr == A_ALTIME);
        wr_alday  = bus_wr && (bus_addr == A_ALDAY);
        wr_sw     = bus_wr && (bus_addr == A_STOPW);
        wr_ien    = bus_wr && (bus_addr == A_IEN);
        wr_stat   = bus_wr && (bus_addr == A_STAT);
    end

    // Control enable register
    always_ff @(posedge clk) begin
        if (!rst_n)       run_en <= 1'b0;
        else if (wr_ctrl) run_en <= bus_wdata[7];
    end

    // Alarm setting registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_sec  <= '0;
            al_min  <= '0;
            al_hour <= '0;
            al_day  <= '0;
        end else begin
            if (wr_altime) begin
                al_sec  <= bus_wdata[SEC_W-1:0];
                al_min  <= bus_wdata[16 +: MIN_W];
                al_hour <= bus_wdata[24 +: HOUR_W];
            end
            if (wr_alday) al_day <= bus_wdata[DAY_W-1:0];
        end
    end

    // Qualified second
    always_comb tick = sec_pulse && run_en;

    rtc_time_chain #(
        .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W),
        .SEC_MAX(60), .MIN_MAX(60), .HOUR_MAX(24)
    ) u_chain (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_time(wr_time), .wr_day(wr_day),
        .w_sec(bus_wdata[SEC_W-1:0]), .w_min(bus_wdata[16 +: MIN_W]),
        .w_hour(bus_wdata[24 +: HOUR_W]), .w_day(bus_wdata[DAY_W-1:0]),
        .sec(sec), .mins(mins), .hour(hour), .day(day),
        .nx_sec(nx_sec), .nx_min(nx_min), .nx_hour(nx_hour), .nx_day(nx_day),
        .ev_sec(ev_sec), .ev_min(ev_min), .ev_hour(ev_hour), .ev_day(ev_day)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk(clk), .rst_n(rst_n), .step(ev_min), .wr(wr_sw),
        .w_val(bus_wdata[SW_W-1:0]), .value(sw_val), .ev_idle(ev_idle)
    );

    // Alarm compare on the updated time and day
    always_comb alarm_hit = tick && (nx_sec == al_sec) && (nx_min == al_min) &&
                            (nx_hour == al_hour) && (nx_day == al_day);

    // Event vector in software-visible bit order
    always_comb begin
        ev_vec           = '0;
        ev_vec[EV_STOPW] = ev_idle;
        ev_vec[EV_MIN]   = ev_min;
        ev_vec[EV_DAY]   = ev_day;
        ev_vec[EV_SEC]   = ev_sec;
        ev_vec[EV_HOUR]  = ev_hour;
        ev_vec[EV_ALARM] = alarm_hit;
    end

    rtc_event_reg #(.NUM_EV(NUM_EV)) u_ev (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_vec),
        .wr_ien(wr_ien), .wr_clr(wr_stat), .w_bits(bus_wdata[NUM_EV-1:0]),
        .ien(ien), .status(status), .irq(irq)
    );

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (rtc_addr_e'(bus_addr))
            A_CTRL:   bus_rdata[7] = run_en;
            A_TIME: begin
                bus_rdata[SEC_W-1:0]   = sec;
                bus_rdata[16 +: MIN_W]  = mins;
                bus_rdata[24 +: HOUR_W] = hour;
            end
            A_DAY:    bus_rdata[DAY_W-1:0] = day;
            A_ALTIME: begin
                bus_rdata[SEC_W-1:0]   = al_sec;
                bus_rdata[16 +: MIN_W]  = al_min;
                bus_rdata[24 +: HOUR_W] = al_hour;
            end
            A_ALDAY:  bus_rdata[DAY_W-1:0]  = al_day;
            A_STOPW:  bus_rdata[SW_W-1:0]   = sw_val;
            A_IEN:    bus_rdata[NUM_EV-1:0] = ien;
            A_STAT:   bus_rdata[NUM_EV-1:0] = status;
            default:  bus_rdata = '0;
        endcase
    end

    // R1
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !bus_wr) |=> ($stable(sec) && $stable(day) && $stable(sw_val) && $stable(status)));
    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_vec & ien)) |=> irq);
endmodule

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_pulse = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    rtc_core u_rtc_core (
        .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state
    int m_en, m_s, m_m, m_h, m_d, m_as, m_am, m_ah, m_ad, m_sw, m_ien, m_st;

    always @(posedge clk) begin
        int ev, ns, nm, nh, nd, nsw;
        if (!rst_n) begin
            m_en = 0; m_s = 0; m_m = 0; m_h = 0; m_d = 0;
            m_as = 0; m_am = 0; m_ah = 0; m_ad = 0;
            m_sw = 63; m_ien = 0; m_st = 0;
        end else begin
            ev = 0; ns = m_s; nm = m_m; nh = m_h; nd = m_d; nsw = m_sw;
            if (m_en != 0 && sec_pulse) begin
                ev |= 16; ns = m_s + 1;
                if (ns >= 60) begin
                    ns = 0; ev |= 2; nm = m_m + 1;
                    if (m_sw != 63) nsw = (m_sw == 0) ? 63 : m_sw - 1;
                    if (nsw == 63) ev |= 1;
                    if (nm >= 60) begin
                        nm = 0; ev |= 32; nh = m_h + 1;
                        if (nh >= 24) begin nh = 0; ev |= 8; nd = (m_d + 1) % 512; end
                    end
                end
                if (ns == m_as && nm == m_am && nh == m_ah && nd == m_ad) ev |= 64;
            end
            if (bus_wr && bus_addr == 3'd7) m_st &= ~int'(bus_wdata[6:0]);
            m_st |= ev & m_ien;
            m_s = ns; m_m = nm; m_h = nh; m_d = nd; m_sw = nsw;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_en = int'(bus_wdata[7]);
                    3'd1: begin m_s = bus_wdata[5:0]; m_m = bus_wdata[21:16]; m_h = bus_wdata[31:24]; end
                    3'd2: m_d = bus_wdata[8:0];
                    3'd3: begin m_as = bus_wdata[5:0]; m_am = bus_wdata[21:16]; m_ah = bus_wdata[31:24]; end
                    3'd4: m_ad = bus_wdata[8:0];
                    3'd5: m_sw = bus_wdata[5:0];
                    3'd6: m_ien = bus_wdata[6:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_en) << 7;
            3'd1: return (32'(m_h) << 24) | (32'(m_m) << 16) | 32'(m_s);
            3'd2: return 32'(m_d);
            3'd3: return (32'(m_ah) << 24) | (32'(m_am) << 16) | 32'(m_as);
            3'd4: return 32'(m_ad);
            3'd5: return 32'(m_sw);
            3'd6: return 32'(m_ien);
            default: return 32'(m_st);
        endcase
    endfunction

    function automatic logic [31:0] tw(input int h, input int m, input int s);
        return (32'(h) << 24) | (32'(m) << 16) | 32'(s);
    endfunction

    // R10: request compared with the model on every cycle
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_st != 0)) begin
                errors++;
                $display("FAIL R10 irq actual=%0b expected=%0b", irq, (m_st != 0));
            end
        end
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); sec_pulse = 1'b1;
        @(negedge clk); sec_pulse = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input string tag);
        bus_addr = a; #1;
        checks++;
        if (bus_rdata !== mread(a)) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, mread(a));
        end
    endtask

    task automatic chk_const(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk_const(3'd1, 32'h0, "R2 reset time");
        chk_const(3'd5, 32'h3F, "R6 reset stopwatch");
        chk_const(3'd7, 32'h0, "R9 reset status");

        // R1: disabled clock ignores pulses
        wr(3'd6, 32'h7F);
        pulse();
        chk_const(3'd1, 32'h0, "R1 disabled time");
        chk_const(3'd7, 32'h0, "R1 disabled status");
        wr(3'd0, 32'hFFFF_FFFF);
        chk_const(3'd0, 32'h80, "R1 control readback");

        // R3: plain second
        pulse();
        chk_const(3'd1, 32'h1, "R3 seconds step");
        chk_const(3'd7, 32'h10, "R3 seconds event");
        wr(3'd7, 32'h7F);
        chk_const(3'd7, 32'h0, "R11 clear");

        // R12: writes raise no events; R2 layout
        wr(3'd1, 32'hFFFF_FFFF);
        chk_const(3'd1, 32'hFF3F_003F, "R2 reserved bits");
        wr(3'd1, tw(0, 5, 59));
        chk_const(3'd7, 32'h0, "R12 no event on write");
        chk(3'd1, "R12 time write");
        // R3 / R7: minute rollover with idle stopwatch
        pulse();
        chk_const(3'd1, tw(0, 6, 0), "R3 minute rollover");
        chk_const(3'd7, 32'h13, "R7 minute events");
        wr(3'd7, 32'h7F);

        // R4: hour rollover
        wr(3'd1, tw(3, 59, 59));
        pulse();
        chk_const(3'd1, tw(4, 0, 0), "R4 hour rollover");
        chk(3'd7, "R4 hour events");
        wr(3'd7, 32'h7F);

        // R4 / R5: day rollover and wrap
        wr(3'd2, 32'd511);
        wr(3'd1, tw(23, 59, 59));
        chk_const(3'd7, 32'h0, "R12 day write quiet");
        pulse();
        chk_const(3'd1, 32'h0, "R4 day rollover time");
        chk_const(3'd2, 32'h0, "R5 day wrap");
        chk(3'd7, "R4 day events");
        wr(3'd7, 32'h7F);

        // R6 / R7: stopwatch countdown over several minutes
        wr(3'd5, 32'd2);
        for (int i = 0; i < 4; i++) begin
            wr(3'd1, tw(1, 10 + i, 59));
            pulse();
            chk(3'd5, "R6 stopwatch step");
            chk(3'd7, "R7 stopwatch event");
            wr(3'd7, 32'h7F);
        end

        // R8: alarm match
        wr(3'd3, tw(7, 30, 0));
        wr(3'd4, 32'd5);
        wr(3'd2, 32'd5);
        wr(3'd1, tw(7, 29, 58));
        pulse();
        chk_const(3'd7, 32'h10, "R8 no early alarm");
        wr(3'd7, 32'h7F);
        pulse();
        chk(3'd7, "R8 alarm event");
        chk_const(3'd7, 32'h53, "R8 alarm bits");
        wr(3'd7, 32'h7F);

        // R9: masked events leave status untouched
        wr(3'd6, 32'h00);
        for (int i = 0; i < 3; i++) pulse();
        chk_const(3'd7, 32'h0, "R9 masked");
        wr(3'd6, 32'h10);
        wr(3'd1, tw(2, 2, 59));
        pulse();
        chk_const(3'd7, 32'h10, "R9 partial mask");

        // R11: clear and set in same cycle keeps the bit
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 32'h10; sec_pulse = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sec_pulse = 1'b0;
        chk_const(3'd7, 32'h10, "R11 set wins");
        wr(3'd7, 32'h10);
        chk_const(3'd7, 32'h0, "R11 cleared");

        // R1: disable again and pulse
        wr(3'd6, 32'h7F);
        wr(3'd0, 32'h0);
        pulse();
        chk(3'd1, "R1 hold after disable");
        chk_const(3'd7, 32'h0, "R1 no event when off");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule